// File: doc/BRIEF.md
# Colour Palette Loader and Pixel Lookup

This block holds a 256-entry colour lookup table with three 8-bit channels and connects it to two clients. A host loads the table through a small byte-addressed register window. It first writes a starting entry number to the index register. It then streams colour bytes into the colour-map register. An internal sequencer sends each byte to the red, green or blue channel of the current entry in turn, and moves to the next entry after blue. A host access to the colour-map register carries either one byte or one 32-bit word. A word is split into four byte steps, and the most significant byte goes first.

The scanout side uses a separate pixel port. It presents an 8-bit pixel index with a valid strobe and gets the packed 24-bit colour one cycle later. Any colour-map byte raises a redraw flag, so the display side knows the palette changed. The display side clears the flag after it has repainted a frame.

The host port follows valid/ready rules. An access is taken on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is high whenever no word is being unpacked. It stays low while the four byte steps of an accepted word are in progress, and the host must hold its access until it sees `host_ready` high. The pixel port applies no back-pressure: every strobe gives exactly one result.

Top module: `clut_palette`

## Requirements
- R1: After reset every entry reads as 0x000000 on the pixel port, the entry pointer is 0, the channel phase is red, `host_ready` is 1 and `redraw` is 1.
- R2: An accepted write to offset 0x0 loads the entry pointer and returns the channel phase to red, even when an earlier entry was only partly written.
- R3: Each colour-map byte step (offset 0x4) writes the current channel of the current entry. The channel order is red, then green, then blue. After blue the phase goes back to red and the pointer moves up by one, so entry 255 is followed by entry 0.
- R4: A write to offset 0x4 with `host_wide`=1 is applied as four byte steps, bits 31:24 first and bits 7:0 last. `host_ready` is 0 for exactly four cycles after the accepting edge.
- R5: `host_rdata` is 0 for every read. An accepted read changes neither the palette, the pointer, the phase nor `redraw`.
- R6: Every colour-map byte step sets `redraw` to 1. A `redraw_clr` pulse clears it when no byte step happens in the same cycle. When both happen in the same cycle, the flag stays set.
- R7: A `pix_in_valid` strobe gives `pix_out_valid`=1 in the next cycle, with `pix_rgb` = {red, green, blue} of `pix_idx` in bits 23:16, 15:8 and 7:0. With no strobe, `pix_out_valid` is 0 in the next cycle.
- R8: When a lookup and a host byte step hit the same entry in the same cycle, the lookup returns the value the entry had before that step.
- R9: Writes to offsets other than 0x0 and 0x4 have no effect. A single-byte colour-map write takes its byte from bits 7:0 of `host_wdata`. An index write takes bits 7:0 of `host_wdata`, whatever the width.
- R10: `host_ready` is 1 whenever no word is being unpacked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Host access accepted when high together with host_valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 32-bit access, 0 = single byte |
| host_addr | input | 3 | Byte offset in the register window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data (always zero) |
| redraw | output | 1 | Palette changed since last clear |
| redraw_clr | input | 1 | Clears redraw |
| pix_in_valid | input | 1 | Lookup strobe |
| pix_idx | input | 8 | Pixel index to look up |
| pix_out_valid | output | 1 | Lookup result valid |
| pix_rgb | output | 24 | Packed colour for the looked-up index |

## Verification
The loader is tested with several kinds of input. Byte streams that start right after reset show whether the pointer and phase reset values are correct. A partial entry that is cut short by an index write shows whether the phase really returns to red. A stream that starts at entry 255 separates a correct wrap to entry 0 from a pointer that runs past the end. A packed word whose four bytes all differ reveals reversed byte order, a skipped step, or a wrong busy length. The word also straddles an entry boundary, so a word that is not tied to entry alignment can be told apart from one that is. Reads and writes to unused offsets are placed between colour bytes, to expose any change they make to the phase. A lookup in the same cycle as a write to the same entry separates a registered read of the old value from a read that sees the new value.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CH_W-1:0]  wdata,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] raddr,
  output logic [CH_W-1:0]  rdata
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [CH_W-1:0] mem [ENTRIES];

  // Storage with reset to zero; reads are registered and see pre-write contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_en)  rdata <= mem[raddr];
  end
endmodule

// File: rtl/clut_host_seq.sv
module clut_host_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CH_W      = 8,
  parameter int unsigned HOST_DW   = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned OFF_INDEX = 0,
  parameter int unsigned OFF_CMAP  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_write,
  input  logic               host_wide,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic               redraw_clr,
  output logic               redraw,
  output logic [NUM_CH-1:0]  step_we,
  output logic [IDX_W-1:0]   step_addr,
  output logic [CH_W-1:0]    step_data,
  output logic [IDX_W-1:0]   cur_idx,
  output phase_e             cur_phase
);
  localparam int unsigned STEPS = HOST_DW / CH_W;
  localparam int unsigned CNT_W = $clog2(STEPS + 1);

  logic               busy;
  logic [HOST_DW-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               accept, hit_idx, hit_cmap, step_go;

  assign host_ready = !busy;
  assign accept     = host_valid && host_ready;
  assign hit_idx    = accept && host_write && (host_addr == ADDR_W'(OFF_INDEX));
  assign hit_cmap   = accept && host_write && (host_addr == ADDR_W'(OFF_CMAP));

  // Byte step source: unpacking word has priority (host is stalled then).
  always_comb begin
    step_go   = 1'b0;
    step_data = host_wdata[CH_W-1:0];
    if (busy) begin
      step_go   = 1'b1;
      step_data = shreg[HOST_DW-1 -: CH_W];
    end else if (hit_cmap && !host_wide) begin
      step_go   = 1'b1;
    end
  end

  assign step_addr = cur_idx;

  always_comb begin
    step_we = '0;
    if (step_go) begin
      unique case (cur_phase)
        PH_GRN:  step_we[1] = 1'b1;
        PH_BLU:  step_we[2] = 1'b1;
        default: step_we[0] = 1'b1;
      endcase
    end
  end

  // Word unpacker: MSB byte first, one step per cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '0;
      left  <= '0;
    end else if (busy) begin
      shreg <= shreg << CH_W;
      left  <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end else if (hit_cmap && host_wide) begin
      busy  <= 1'b1;
      shreg <= host_wdata;
      left  <= CNT_W'(STEPS);
    end
  end

  // Entry pointer and channel phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      cur_phase <= PH_RED;
    end else if (hit_idx) begin
      cur_idx   <= host_wdata[IDX_W-1:0];
      cur_phase <= PH_RED;
    end else if (step_go) begin
      unique case (cur_phase)
        PH_RED:  cur_phase <= PH_GRN;
        PH_GRN:  cur_phase <= PH_BLU;
        default: begin
          cur_phase <= PH_RED;
          cur_idx   <= cur_idx + 1'b1;
        end
      endcase
    end
  end

  // Redraw flag: set by any byte step, set wins over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          redraw <= 1'b1;
    else if (step_go)    redraw <= 1'b1;
    else if (redraw_clr) redraw <= 1'b0;
  end
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CH_W      = 8,
  parameter int unsigned HOST_DW   = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned OFF_INDEX = 0,
  parameter int unsigned OFF_CMAP  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_valid,
  output logic                     host_ready,
  input  logic                     host_write,
  input  logic                     host_wide,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [HOST_DW-1:0]       host_wdata,
  output logic [HOST_DW-1:0]       host_rdata,
  output logic                     redraw,
  input  logic                     redraw_clr,
  input  logic                     pix_in_valid,
  input  logic [IDX_W-1:0]         pix_idx,
  output logic                     pix_out_valid,
  output logic [NUM_CH*CH_W-1:0]   pix_rgb
);
  logic [NUM_CH-1:0] step_we;
  logic [IDX_W-1:0]  step_addr;
  logic [CH_W-1:0]   step_data;
  logic [IDX_W-1:0]  cur_idx;
  phase_e            cur_phase;

  assign host_rdata = '0;

  clut_host_seq #(
    .IDX_W(IDX_W), .CH_W(CH_W), .HOST_DW(HOST_DW), .ADDR_W(ADDR_W),
    .OFF_INDEX(OFF_INDEX), .OFF_CMAP(OFF_CMAP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_wide(host_wide),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .redraw_clr(redraw_clr), .redraw(redraw),
    .step_we(step_we), .step_addr(step_addr), .step_data(step_data),
    .cur_idx(cur_idx), .cur_phase(cur_phase)
  );

  // One bank per channel; channel 0 (red) lands in the top byte.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    clut_bank #(.IDX_W(IDX_W), .CH_W(CH_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(step_we[ch]), .waddr(step_addr), .wdata(step_data),
      .rd_en(pix_in_valid), .raddr(pix_idx),
      .rdata(pix_rgb[(NUM_CH-ch)*CH_W-1 -: CH_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out_valid <= 1'b0;
    else        pix_out_valid <= pix_in_valid;
  end
endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned HOST_DW   = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned OFF_INDEX = 0,
  parameter int unsigned OFF_CMAP  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_ready,
  input logic               host_write,
  input logic               host_wide,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [HOST_DW-1:0] host_wdata,
  input logic               redraw,
  input logic               redraw_clr,
  input logic               pix_in_valid,
  input logic               pix_out_valid,
  input logic [IDX_W-1:0]   cur_idx,
  input phase_e             cur_phase
);
  logic acc_idx, acc_byte, acc_word;
  assign acc_idx  = host_valid && host_ready && host_write && host_addr == ADDR_W'(OFF_INDEX);
  assign acc_byte = host_valid && host_ready && host_write && host_addr == ADDR_W'(OFF_CMAP) && !host_wide;
  assign acc_word = host_valid && host_ready && host_write && host_addr == ADDR_W'(OFF_CMAP) && host_wide;

  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    acc_idx |=> (cur_idx == $past(host_wdata[IDX_W-1:0])) && (cur_phase == PH_RED));

  a_r3_wrap_after_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_byte && cur_phase == PH_BLU) |=> (cur_phase == PH_RED) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  a_r4_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    acc_word |=> !host_ready ##1 !host_ready ##1 !host_ready ##1 !host_ready ##1 host_ready);

  a_r6_redraw_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_byte |=> redraw);

  a_r6_redraw_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(redraw) |-> $past(redraw_clr));

  a_r7_out_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_valid |=> pix_out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_in_valid |=> !pix_out_valid);
endmodule

bind clut_palette clut_palette_chk #(
  .IDX_W(IDX_W), .HOST_DW(HOST_DW), .ADDR_W(ADDR_W),
  .OFF_INDEX(OFF_INDEX), .OFF_CMAP(OFF_CMAP)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_valid(host_valid), .host_ready(host_ready),
  .host_write(host_write), .host_wide(host_wide),
  .host_addr(host_addr), .host_wdata(host_wdata),
  .redraw(redraw), .redraw_clr(redraw_clr),
  .pix_in_valid(pix_in_valid), .pix_out_valid(pix_out_valid),
  .cur_idx(cur_idx), .cur_phase(cur_phase)
);

// File: tb/sim_clut_palette.sv
`timescale 1ns/1ps
module sim_clut_palette;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0, host_wide = 1'b0;
  logic        host_ready;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        redraw, redraw_clr = 1'b0;
  logic        pix_in_valid = 1'b0, pix_out_valid;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  always #4 clk = ~clk;

  clut_palette u0 (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_wide(host_wide),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .redraw(redraw), .redraw_clr(redraw_clr),
    .pix_in_valid(pix_in_valid), .pix_idx(pix_idx),
    .pix_out_valid(pix_out_valid), .pix_rgb(pix_rgb)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference model built from the requirements.
  logic [7:0] mr [256], mg [256], mb [256];
  logic [7:0] midx = '0;
  int         mph = 0;
  logic [23:0] exp_q [$];
  string       tag_q [$];
  int          last_busy;

  function automatic logic [23:0] mrgb(input logic [7:0] i);
    return {mr[i], mg[i], mb[i]};
  endfunction

  task automatic model_byte(input logic [7:0] b);
    if (mph == 0) mr[midx] = b;
    else if (mph == 1) mg[midx] = b;
    else mb[midx] = b;
    if (mph == 2) begin mph = 0; midx = midx + 8'd1; end
    else mph = mph + 1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one host access, waits for ready, updates the model.
  task automatic host_op(input bit wr, input bit wide, input logic [2:0] a,
                         input logic [31:0] d, input bit clr);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_wide = wide; host_addr = a;
    host_wdata = d; redraw_clr = clr;
    @(negedge clk);
    host_valid = 1'b0; redraw_clr = 1'b0;
    last_busy = 0;
    if (wr && a == 3'd0) begin midx = d[7:0]; mph = 0; end
    if (wr && a == 3'd4) begin
      if (wide) begin
        for (int k = 3; k >= 0; k--) model_byte(d[k*8 +: 8]);
        while (!host_ready) begin last_busy++; @(negedge clk); end
      end else model_byte(d[7:0]);
    end
  endtask

  task automatic lookup(input logic [7:0] i, input string tag);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_idx = i;
    exp_q.push_back(mrgb(i)); tag_q.push_back(tag);
    @(negedge clk);
    pix_in_valid = 1'b0;
  endtask

  // Monitor: pops expected colours as results appear.
  always @(negedge clk) begin
    if (rst_n && pix_out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected result", {8'h0, pix_rgb}, 32'h0);
      else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(pix_rgb === e, t, {8'h0, pix_rgb}, {8'h0, e});
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(redraw === 1'b1, "R1 redraw after reset", {31'h0, redraw}, 32'h1);
    check(host_ready === 1'b1, "R10 ready idle", {31'h0, host_ready}, 32'h1);
    check(pix_out_valid === 1'b0, "R7 no result without strobe", {31'h0, pix_out_valid}, 32'h0);
    lookup(8'd0, "R1 entry 0 cleared");
    lookup(8'd128, "R1 entry 128 cleared");
    lookup(8'd255, "R1 entry 255 cleared");

    // R6 clear
    @(negedge clk); redraw_clr = 1'b1; @(negedge clk); redraw_clr = 1'b0;
    check(redraw === 1'b0, "R6 clear", {31'h0, redraw}, 32'h0);

    // R1 pointer 0 / red after reset, R3 order
    host_op(1, 0, 3'd4, 32'hFFFF_FF11, 0);
    check(redraw === 1'b1, "R6 set by byte", {31'h0, redraw}, 32'h1);
    host_op(1, 0, 3'd4, 32'h0000_0022, 0);
    host_op(1, 0, 3'd4, 32'h0000_0033, 0);
    lookup(8'd0, "R3 entry 0 RGB order");
    lookup(8'd1, "R3 entry 1 untouched");

    // R9 wide index write, R2 phase reset mid-entry
    host_op(1, 1, 3'd0, 32'hAABB_CC05, 0);
    host_op(1, 0, 3'd4, 32'h0000_0044, 0);
    host_op(1, 0, 3'd0, 32'h0000_0005, 0);
    host_op(1, 0, 3'd4, 32'h0000_0055, 0);
    host_op(1, 0, 3'd4, 32'h0000_0066, 0);
    host_op(1, 0, 3'd4, 32'h0000_0077, 0);
    lookup(8'd5, "R2 index write resets phase");

    // R3 wrap 255 -> 0
    host_op(1, 0, 3'd0, 32'h0000_00FF, 0);
    host_op(1, 0, 3'd4, 32'h01, 0);
    host_op(1, 0, 3'd4, 32'h02, 0);
    host_op(1, 0, 3'd4, 32'h03, 0);
    host_op(1, 0, 3'd4, 32'h09, 0);
    lookup(8'd255, "R3 entry 255");
    lookup(8'd0, "R3 wrap to entry 0");

    // R4 word unpack across entries
    host_op(1, 0, 3'd0, 32'h0000_000A, 0);
    host_op(1, 1, 3'd4, 32'h8090_A0B0, 0);
    check(last_busy == 4, "R4 ready low cycles", last_busy, 4);
    lookup(8'd10, "R4 word bytes MSB first");
    lookup(8'd11, "R4 fourth byte to next entry");
    host_op(1, 0, 3'd4, 32'h0000_00C1, 0);
    lookup(8'd11, "R4 phase continues after word");

    // R5 reads
    @(negedge clk); redraw_clr = 1'b1; @(negedge clk); redraw_clr = 1'b0;
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_wide = 1'b1; host_addr = 3'd0;
    #1 check(host_rdata === 32'h0, "R5 index read zero", host_rdata, 32'h0);
    @(negedge clk);
    host_addr = 3'd4;
    #1 check(host_rdata === 32'h0, "R5 cmap read zero", host_rdata, 32'h0);
    @(negedge clk);
    host_valid = 1'b0;
    check(redraw === 1'b0, "R5 read leaves redraw", {31'h0, redraw}, 32'h0);
    host_op(1, 0, 3'd4, 32'h0000_00D2, 0);
    lookup(8'd11, "R5 read leaves phase");

    // R9 unused offsets ignored
    @(negedge clk); redraw_clr = 1'b1; @(negedge clk); redraw_clr = 1'b0;
    host_op(1, 0, 3'd2, 32'h0000_00EE, 0);
    host_op(1, 1, 3'd6, 32'hEEEE_EEEE, 0);
    check(redraw === 1'b0, "R9 unused offset no redraw", {31'h0, redraw}, 32'h0);
    host_op(1, 0, 3'd4, 32'h0000_0012, 0);
    lookup(8'd12, "R9 unused offsets leave pointer");
    lookup(8'd11, "R9 unused offsets leave palette");

    // R6 set wins over clear
    host_op(1, 0, 3'd4, 32'h0000_0034, 1);
    check(redraw === 1'b1, "R6 set wins over clear", {31'h0, redraw}, 32'h1);

    // R8 same-cycle write and lookup
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_wide = 1'b0; host_addr = 3'd4;
    host_wdata = 32'h0000_0056;
    pix_in_valid = 1'b1; pix_idx = midx;
    exp_q.push_back(mrgb(midx)); tag_q.push_back("R8 old value on collision");
    @(negedge clk);
    host_valid = 1'b0; pix_in_valid = 1'b0;
    model_byte(8'h56);
    lookup(8'd12, "R8 new value afterwards");

    // R7 back-to-back lookups
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ii;
      ii = (k == 0) ? 8'd0 : (k == 1) ? 8'd5 : (k == 2) ? 8'd10 : 8'd255;
      pix_in_valid = 1'b1; pix_idx = ii;
      exp_q.push_back(mrgb(ii)); tag_q.push_back("R7 streamed lookup");
      @(negedge clk);
    end
    pix_in_valid = 1'b0;
    @(negedge clk);
    check(pix_out_valid === 1'b0, "R7 valid drops", {31'h0, pix_out_valid}, 32'h0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule